// File: doc/BRIEF.md
# Character Height Line Repeater

This block stretches one row of on-screen characters to a taller programmed height. The font cell is 18 scan lines tall. When the height code asks for more lines, the block repeats some font lines so that the extra lines are spread evenly down the cell. It sits between the vertical scan timing and the font fetch logic. Each output scan line of a character row raises `line_adv` for one cycle. The block answers with the font line (1..18) that the fetch logic should read. After the final repeat of line 18 it raises `row_done`.

The extra lines come from the excess height, E = code − 18, where codes of 18 or less count as 18. Each full group of 14 extra lines adds one extra emission to every eligible line, lines 3 through 16. The remainder, r, is the number of extra lines left over after the full groups. It sets a spacing M = round(14 / r), with halves rounded up. The eligible lines at index 2 + N·M, for N = 1, 2, …, get one more emission on top of that. Both the tier count and the spacing are decoded from the height code when the row starts, so no divider runs while scan lines are being produced.

Top module: `char_height_repeater`

## Requirements
- R1: After reset, `font_line` is 1 and `row_done` is 0.
- R2: A `row_start` pulse sets `font_line` to 1 and clears `row_done` on the next clock edge. In the same cycle it captures `height_code`. When `row_start` and `line_adv` arrive together, `row_start` wins.
- R3: A height code of 18 or less emits each font line 1..18 exactly once. `row_done` is then set after 18 advances.
- R4: Font lines 1, 2, 17 and 18 are each emitted exactly once, whatever the height code.
- R5: With E = code − 18 and tier k = (E − 1) div 14 for E ≥ 1 (k = 0 when E = 0), every line 3..16 is emitted at least k + 1 times.
- R6: With r = E − 14k and M = round-half-up(14 / r), each line L in 3..16 with (L − 2) mod M = 0 is emitted k + 2 times. The row therefore lasts 18 + 14k + floor(14 / M) scan lines.
- R7: Each `line_adv` leaves `font_line` unchanged or raises it by exactly 1. Without `line_adv` or `row_start`, `font_line` and `row_done` hold their values.
- R8: `row_done` rises on the advance that ends the last emission of line 18. It then stays high with `font_line` at 18, and further `line_adv` pulses are ignored until the next `row_start`.
- R9: Changes on `height_code` after `row_start` do not affect the row in progress.
- R10: Height code 32 emits lines 3..16 twice each, for 32 scan lines in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_start | input | 1 | One-cycle pulse that begins a character row and captures the height code |
| line_adv | input | 1 | One-cycle pulse that moves to the next output scan line |
| height_code | input | 6 | Programmed character height in scan lines (18..63; lower values act as 18) |
| font_line | output | 5 | Font line to fetch for the current output scan line, 1..18 |
| row_done | output | 1 | High once every scan line of the row has been produced |

## Verification
The bench builds the block with its fixed font geometry: an 18-line cell, 14 eligible lines and up to three tiers. With that geometry the 6-bit height code has only 64 values, so the bench sweeps every one of them. Each row is checked scan line by scan line against an arithmetic model of the tier and spacing rule. This covers every remainder from 1 to 14 and every tier from 0 to 3, including the codes at the tier boundaries (32, 33, 46, 47, 60, 61) and the codes at 18 and below. Some rows also insert idle cycles, change the height code in the middle of the row, or pulse `row_start` together with an advance.

// File: rtl/chr_hrep_pkg.sv
// Package: font cell geometry and the height-code decode shared by the
// line repeater. Assumes an 18-line cell in which only lines 3..16 may repeat.
package chr_hrep_pkg;

    localparam int FONT_LINES = 18;
    localparam int REP_FIRST  = 3;
    localparam int REP_LAST   = 16;
    localparam int SPAN       = REP_LAST - REP_FIRST + 1;
    localparam int MAX_TIER   = 3;
    localparam int CODE_W     = 6;
    localparam int LINE_W     = $clog2(FONT_LINES + 1);
    localparam int SPC_W      = $clog2(SPAN + 1);
    localparam int TIER_W     = $clog2(MAX_TIER + 1);
    localparam int CNT_W      = $clog2(MAX_TIER + 3);

    // Per-row repeat settings: full tiers, and spacing of extra lines (0 = none).
    typedef struct packed {
        logic [TIER_W-1:0] tier;
        logic [SPC_W-1:0]  spacing;
    } hrep_cfg_t;

    // Turns a height code into tier and spacing using constant multiplies only.
    function automatic hrep_cfg_t decode_height(input logic [CODE_W-1:0] code);
        hrep_cfg_t res;
        int excess;
        int tier;
        int rem;
        int m;
        excess = (int'(code) > FONT_LINES) ? int'(code) - FONT_LINES : 0;
        tier = 0;
        for (int t = 1; t <= MAX_TIER; t++) begin
            if (excess > t * SPAN) tier = t;
        end
        rem = excess - tier * SPAN;
        m = 0;
        if (rem > 0) begin
            // round-half-up(SPAN/rem) is the largest c with (2c-1)*rem <= 2*SPAN
            for (int c = 1; c <= SPAN; c++) begin
                if ((2 * c - 1) * rem <= 2 * SPAN) m = c;
            end
        end
        res.tier    = TIER_W'(tier);
        res.spacing = SPC_W'(m);
        return res;
    endfunction

endpackage

// File: rtl/hrep_cfg_latch.sv
// Module: decodes the height code into tier and spacing, and holds the result
// for the whole character row. Assumes row_start is a one-cycle pulse.
module hrep_cfg_latch
    import chr_hrep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic [CODE_W-1:0] height_code,
    output hrep_cfg_t         cfg
);

    // Capture the decoded settings once per row.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (row_start)
            cfg <= decode_height(height_code);
    end

    AST_SPACING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.spacing <= SPC_W'(SPAN)); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !row_start |=> $stable(cfg)); // R9

endmodule

// File: rtl/hrep_line_stepper.sv
// Module: walks the font lines of one character row. Every scan line is
// counted against the number of emissions the current font line needs.
// Assumes cfg is stable for the whole row; it may change only at row_start.
module hrep_line_stepper
    import chr_hrep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic              line_adv,
    input  hrep_cfg_t         cfg,
    output logic [LINE_W-1:0] line_q,
    output logic              done_q
);

    localparam logic [LINE_W-1:0] L_ONE   = LINE_W'(1);
    localparam logic [LINE_W-1:0] L_FIRST = LINE_W'(REP_FIRST);
    localparam logic [LINE_W-1:0] L_LAST  = LINE_W'(REP_LAST);
    localparam logic [LINE_W-1:0] L_END   = LINE_W'(FONT_LINES);

    logic [CNT_W-1:0] rep_q;
    logic             sel_q;
    logic [SPC_W-1:0] phase_q;

    logic             elig;
    logic [CNT_W-1:0] need;
    logic             last_rep;
    logic [LINE_W-1:0] nxt_line;
    logic             nxt_elig;
    logic [SPC_W-1:0] ph_inc;
    logic             hit;

    // Emission count for the current line, and selection for the next line.
    always_comb begin
        elig     = (line_q >= L_FIRST) && (line_q <= L_LAST);
        need     = CNT_W'(1) + (elig ? (CNT_W'(cfg.tier) + CNT_W'(sel_q)) : '0);
        last_rep = (rep_q == need - CNT_W'(1));
        nxt_line = line_q + L_ONE;
        nxt_elig = (nxt_line >= L_FIRST) && (nxt_line <= L_LAST);
        ph_inc   = phase_q + SPC_W'(1);
        hit      = nxt_elig && (cfg.spacing != '0) && (ph_inc == cfg.spacing);
    end

    // Step the repeat counter, the font line and the spacing phase.
    always_ff @(posedge clk) begin
        if (!rst_n || row_start) begin
            line_q  <= L_ONE;
            rep_q   <= '0;
            sel_q   <= 1'b0;
            phase_q <= '0;
            done_q  <= 1'b0;
        end else if (line_adv && !done_q) begin
            if (!last_rep) begin
                rep_q <= rep_q + CNT_W'(1);
            end else begin
                rep_q <= '0;
                if (line_q == L_END) begin
                    done_q <= 1'b1;
                end else begin
                    line_q <= nxt_line;
                    if (nxt_elig && cfg.spacing != '0) begin
                        sel_q   <= hit;
                        phase_q <= hit ? '0 : ph_inc;
                    end else begin
                        sel_q <= 1'b0;
                    end
                end
            end
        end
    end

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_q >= L_ONE && line_q <= L_END); // R7

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> line_q == L_ONE && !done_q); // R2

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv && !row_start && !done_q |=>
        (line_q == $past(line_q) || line_q == $past(line_q) + L_ONE)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv && !row_start |=> $stable(line_q) && $stable(done_q)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !row_start |=> done_q && line_q == L_END); // R8

    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv && !row_start && !done_q && (line_q < L_FIRST || line_q > L_LAST) |=>
        (line_q != $past(line_q) || done_q)); // R4

endmodule

// File: rtl/char_height_repeater.sv
// Module: top of the character height line repeater. It joins the per-row
// settings latch to the line stepper. Assumes row_start comes before the
// first line_adv of each character row.
module char_height_repeater
    import chr_hrep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic              line_adv,
    input  logic [CODE_W-1:0] height_code,
    output logic [LINE_W-1:0] font_line,
    output logic              row_done
);

    hrep_cfg_t row_cfg;

    hrep_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_start   (row_start),
        .height_code (height_code),
        .cfg         (row_cfg)
    );

    hrep_line_stepper u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_start (row_start),
        .line_adv  (line_adv),
        .cfg       (row_cfg),
        .line_q    (font_line),
        .done_q    (row_done)
    );

endmodule

// File: tb/test_char_height_repeater.sv
module test_char_height_repeater;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_start = 1'b0;
    logic       line_adv = 1'b0;
    logic [5:0] height_code = 6'd0;
    logic [4:0] font_line;
    logic       row_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    char_height_repeater i_char_height_repeater (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_start   (row_start),
        .line_adv    (line_adv),
        .height_code (height_code),
        .font_line   (font_line),
        .row_done    (row_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic adv();
        line_adv = 1'b1;
        tick();
        line_adv = 1'b0;
    endtask

    function automatic int excess_of(input int h);
        return (h > 18) ? h - 18 : 0;
    endfunction

    function automatic int tier_of(input int h);
        int e;
        e = excess_of(h);
        return (e > 0) ? (e - 1) / 14 : 0;
    endfunction

    function automatic int spacing_of(input int h);
        int r;
        r = excess_of(h) - 14 * tier_of(h);
        return (r > 0) ? (28 + r) / (2 * r) : 0;
    endfunction

    // Expected emissions of font line L (R4, R5, R6).
    function automatic int need_of(input int h, input int L);
        int n;
        int m;
        if (L < 3 || L > 16) return 1;
        n = 1 + tier_of(h);
        m = spacing_of(h);
        if (m > 0 && ((L - 2) % m) == 0) n++;
        return n;
    endfunction

    task automatic run_row(input int h, input int alt_h, input bit idle);
        int count;
        int total;
        string tg;
        height_code = 6'(h);
        row_start = 1'b1;
        tick();
        row_start = 1'b0;
        if (alt_h >= 0) height_code = 6'(alt_h);
        chk(font_line == 5'd1 && !row_done, "R2", font_line, 1);
        count = 0;
        for (int L = 1; L <= 18; L++) begin
            for (int i = 0; i < need_of(h, L); i++) begin
                if (alt_h >= 0) tg = "R9";
                else if (h <= 18) tg = "R3";
                else if (L < 3 || L > 16) tg = "R4";
                else if (h == 32) tg = "R10";
                else if (i > tier_of(h)) tg = "R6";
                else tg = "R5";
                chk(font_line == 5'(L), tg, font_line, L);
                chk(!row_done, "R8", row_done, 0);
                adv();
                count++;
                if (idle) begin
                    tick();
                    if (count < 18 + 14 * tier_of(h)) begin
                        chk(!row_done && (font_line == 5'(L) || font_line == 5'(L + 1)),
                            "R7", font_line, L);
                    end
                end
            end
        end
        total = 18 + 14 * tier_of(h) + ((spacing_of(h) > 0) ? 14 / spacing_of(h) : 0);
        chk(count == total, (h == 32) ? "R10" : "R6", count, total);
        chk(row_done && font_line == 5'd18, "R8", font_line, 18);
        adv();
        chk(row_done && font_line == 5'd18, "R8", font_line, 18);
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick();
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        chk(font_line == 5'd1 && !row_done, "R1", font_line, 1);

        // R10 first, then the full sweep of codes, with variations mixed in.
        run_row(32, -1, 1'b0);
        for (int h = 0; h < 64; h++) begin
            run_row(h, (h % 9 == 4) ? 63 - h : -1, (h % 7 == 0));
        end

        // R2 priority: row_start together with line_adv.
        row_start = 1'b1;
        line_adv = 1'b1;
        tick();
        row_start = 1'b0;
        line_adv = 1'b0;
        chk(font_line == 5'd1 && !row_done, "R2", font_line, 1);
        tick();
        chk(font_line == 5'd1, "R7", font_line, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule